// File: doc/BRIEF.md
# Latched Error Status and Interrupt Mask

This block collects error and status indications for a network interface node. It keeps a 16-bit status word and a 16-bit mask word. Some status positions latch one-cycle event pulses from the transmit queue, the interrupt queue, the receiver, the retry logic, the redundant link and a general-purpose counter. The other positions show live levels. When a status bit meets a set mask bit and error interrupts are globally enabled, the block raises an interrupt request.

The host reaches both words through a simple register port. `regSel` picks the word and `rdEn`/`wrEn` qualify the access. Reading the status word clears only its latched positions. Writing the status word does not change its contents; it only re-arms the interrupt. After the request fires once, it stays quiet until that re-arm arrives. This gives the service routine a single notification per pass.

Top module: `err_status_unit`

## Requirements
- R1: Status word layout. Latched positions are 0, 2, 4, 6 to 13 (bit 0 transmit queue full, 2 transmit queue 7/8 full, 4 interrupt queue full, 6 carrier loss, 7 bad message, 8 receive overflow, 9 retry, 10 retry timeout, 11 redundant link fault, 12 counter overflow, 13 spare). Live positions 1, 5, 14 and 15 mirror `liveIn` at the same positions. Bit 3 always reads 0.
- R2: A pulse on `evtIn` at a latched position sets that status bit at the next clock edge. The bit then holds until it is cleared. `evtIn` at non-latched positions has no effect.
- R3: A status read (`regSel`=0, `rdEn`=1) returns the current word in that cycle and clears every latched bit at the clock edge. Live bits are not affected.
- R4: An event that arrives in the same cycle as a clearing read is still set after that read.
- R5: The mask word is written with `regSel`=1 and `wrEn`=1, and it reads back through `rdData` with `regSel`=1.
- R6: `irqReq` is raised only when `errIntEn` is 1 and the status word ANDed with the mask is non-zero. A zero mask, or `errIntEn` at 0, keeps it low. This includes a counter overflow with mask bit 12 set.
- R7: With the mask at all ones, any set error bit raises `irqReq`.
- R8: `irqReq` is a one-cycle pulse. It goes high at the clock edge after the request condition is seen while armed. It then stays low, even while the condition remains, until a status write (`regSel`=0, `wrEn`=1) re-arms it. If the condition still holds, it fires again one edge after the re-arm.
- R9: After reset the mask is 0, all latched bits are 0, the interrupt is armed and `irqReq` is 0.
- R10: A status write leaves the status bits unchanged, whatever the value of `wrData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtIn | input | 16 | One-cycle event pulses, used at latched positions |
| liveIn | input | 16 | Live status levels, used at live positions |
| errIntEn | input | 1 | Global interrupt-on-errors enable |
| regSel | input | 1 | 0 selects the status word, 1 selects the mask word |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the selected word |
| irqReq | output | 1 | Error interrupt request pulse |

## Verification
The bench raises an event in the same cycle as a clearing read. A design that cleared first would lose that event. It also checks that a read leaves the live bits alone and that a status write with all ones in `wrData` does not set any bit. After a request fires, the bench keeps the masked condition present. A design without the arm state would pulse again on every cycle, and one that ignored the re-arm would never fire a second time. Finally, the bench sets the counter overflow bit while the global enable is low and then raises the enable, to show that the enable gates the request.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;
  localparam int WORD_W = 16;
  // positions that capture event pulses and are cleared by a status read
  localparam logic [WORD_W-1:0] LATCH_BITS = 16'h3FD5;
  // positions that mirror live levels
  localparam logic [WORD_W-1:0] LIVE_BITS  = 16'hC022;

  typedef struct packed {
    logic clrLatched;
    logic rearm;
    logic loadMask;
  } strobe_t;
endpackage

// File: rtl/err_stat_ctrl.sv
module err_stat_ctrl
  import err_stat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rdEn,
  input  logic    wrEn,
  input  logic    regSel,
  input  logic    errIntEn,
  input  logic    pending,
  output strobe_t strb,
  output logic    irqReq
);
  logic armed;
  logic fire;

  always_comb begin
    strb.clrLatched = rdEn && !regSel;
    strb.rearm      = wrEn && !regSel;
    strb.loadMask   = wrEn && regSel;
  end

  assign fire = armed && errIntEn && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b1;
      irqReq <= 1'b0;
    end else begin
      irqReq <= fire;
      if (strb.rearm)  armed <= 1'b1;
      else if (fire)   armed <= 1'b0;
    end
  end
endmodule

// File: rtl/err_stat_dp.sv
module err_stat_dp
  import err_stat_pkg::*;
#(
  parameter int W = WORD_W
)(
  input  logic         clk,
  input  logic         rst_n,
  input  strobe_t      strb,
  input  logic         regSel,
  input  logic [W-1:0] evtIn,
  input  logic [W-1:0] liveIn,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] statusWord,
  output logic [W-1:0] maskWord,
  output logic [W-1:0] rdData,
  output logic         pending
);
  localparam logic [W-1:0] LATCH_M = W'(LATCH_BITS);
  localparam logic [W-1:0] LIVE_M  = W'(LIVE_BITS);

  logic [W-1:0] latched;
  logic [W-1:0] keepBits;

  // a clearing read drops old bits, but events of the same cycle still land
  assign keepBits = strb.clrLatched ? '0 : latched;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched  <= '0;
      maskWord <= '0;
    end else begin
      latched <= (keepBits | evtIn) & LATCH_M;
      if (strb.loadMask) maskWord <= wrData;
    end
  end

  assign statusWord = latched | (liveIn & LIVE_M);
  assign pending    = |(statusWord & maskWord);
  assign rdData     = regSel ? maskWord : statusWord;
endmodule

// File: rtl/err_status_unit.sv
module err_status_unit
  import err_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] evtIn,
  input  logic [15:0] liveIn,
  input  logic        errIntEn,
  input  logic        regSel,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        irqReq
);
  strobe_t     strb;
  logic        pending;
  logic [15:0] statusWord;
  logic [15:0] maskWord;

  err_stat_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rdEn(rdEn), .wrEn(wrEn), .regSel(regSel),
    .errIntEn(errIntEn), .pending(pending), .strb(strb), .irqReq(irqReq)
  );

  err_stat_dp #(.W(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regSel(regSel), .evtIn(evtIn),
    .liveIn(liveIn), .wrData(wrData), .statusWord(statusWord),
    .maskWord(maskWord), .rdData(rdData), .pending(pending)
  );
endmodule

// File: rtl/err_status_unit_chk.sv
module err_status_unit_chk
  import err_stat_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] evtIn,
  input logic        errIntEn,
  input logic        regSel,
  input logic        rdEn,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        irqReq,
  input logic [15:0] statusWord,
  input logic [15:0] maskWord
);
  assert_bit3_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !regSel |-> ((rdData & 16'h0008) == 16'h0000));

  assert_event_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evtIn & LATCH_BITS)) |=>
      ((statusWord & $past(evtIn) & LATCH_BITS) == ($past(evtIn) & LATCH_BITS)));

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !regSel) |=> ((statusWord & LATCH_BITS & ~$past(evtIn)) == 16'h0000));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && regSel) |=> (maskWord == $past(wrData)));

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> ($past(errIntEn) && ($past(statusWord & maskWord) != 16'h0000)));

  assert_irq_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |=> !irqReq);
endmodule

bind err_status_unit err_status_unit_chk u_chk (.*);

// File: tb/err_status_unit_bench.sv
`timescale 1ns/1ps
module err_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evtIn, liveIn, wrData;
  logic        errIntEn, regSel, rdEn, wrEn;
  logic [15:0] rdData;
  logic        irqReq;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  err_status_unit u_err_status_unit (
    .clk(clk), .rst_n(rst_n), .evtIn(evtIn), .liveIn(liveIn),
    .errIntEn(errIntEn), .regSel(regSel), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irqReq(irqReq)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic sel, output logic [15:0] v);
    regSel = sel; #0.1; v = rdData;
  endtask

  task automatic writeReg(input logic sel, input logic [15:0] d);
    regSel = sel; wrData = d; wrEn = 1'b1; cyc(); wrEn = 1'b0;
  endtask

  task automatic readClear();
    regSel = 1'b0; rdEn = 1'b1; cyc(); rdEn = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] e);
    evtIn = e; cyc(); evtIn = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(1'b0, v); check(v == 16'h0000, "R9 status after reset", v, 16'h0000);
    peek(1'b1, v); check(v == 16'h0000, "R9 mask after reset", v, 16'h0000);
    check(irqReq == 1'b0, "R9 irq after reset", {15'd0, irqReq}, 16'h0000);
    liveIn = 16'hFFFF;
    peek(1'b0, v); check(v == 16'hC022, "R1 live positions", v, 16'hC022);
    liveIn = 16'h0000;
  endtask

  task automatic t_latch();
    logic [15:0] v;
    pulse(16'hFFFF);
    peek(1'b0, v); check(v == 16'h3FD5, "R1 R2 latched layout bit3 zero", v, 16'h3FD5);
    cyc();
    peek(1'b0, v); check(v == 16'h3FD5, "R2 bits hold", v, 16'h3FD5);
  endtask

  task automatic t_readClear();
    logic [15:0] v;
    liveIn = 16'hFFFF;
    peek(1'b0, v); check(v == 16'hFFF7, "R3 read value before clear", v, 16'hFFF7);
    readClear();
    peek(1'b0, v); check(v == 16'hC022, "R3 latched cleared live kept", v, 16'hC022);
    liveIn = 16'h0000;
  endtask

  task automatic t_sameCycle();
    logic [15:0] v;
    pulse(16'h0201);
    regSel = 1'b0; rdEn = 1'b1; evtIn = 16'h0040; cyc(); rdEn = 1'b0; evtIn = '0;
    peek(1'b0, v); check(v == 16'h0040, "R4 event during read survives", v, 16'h0040);
    readClear();
  endtask

  task automatic t_mask();
    logic [15:0] v;
    writeReg(1'b1, 16'hA5A5);
    peek(1'b1, v); check(v == 16'hA5A5, "R5 mask readback", v, 16'hA5A5);
    writeReg(1'b1, 16'h0000);
    pulse(16'h0004);
    writeReg(1'b0, 16'hFFFF);
    peek(1'b0, v); check(v == 16'h0004, "R10 status write ignores data", v, 16'h0004);
    readClear();
  endtask

  task automatic t_irq();
    int highs;
    writeReg(1'b0, 16'h0000);          // arm
    writeReg(1'b1, 16'h1000);
    errIntEn = 1'b0;
    pulse(16'h1000);
    highs = 0;
    for (int i = 0; i < 4; i++) begin cyc(); if (irqReq) highs++; end
    check(highs == 0, "R6 counter overflow gated by enable", 16'(highs), 16'd0);
    errIntEn = 1'b1; cyc();
    check(irqReq == 1'b1, "R6 irq once enabled", {15'd0, irqReq}, 16'h0001);
    cyc();
    check(irqReq == 1'b0, "R8 irq is one cycle", {15'd0, irqReq}, 16'h0000);
    pulse(16'h1000);
    highs = 0;
    for (int i = 0; i < 5; i++) begin cyc(); if (irqReq) highs++; end
    check(highs == 0, "R8 no refire before rearm", 16'(highs), 16'd0);
    writeReg(1'b0, 16'h0000);
    check(irqReq == 1'b0, "R8 rearm edge", {15'd0, irqReq}, 16'h0000);
    cyc();
    check(irqReq == 1'b1, "R8 fires after rearm", {15'd0, irqReq}, 16'h0001);
    writeReg(1'b1, 16'h0000);
    readClear();
    writeReg(1'b0, 16'h0000);
  endtask

  task automatic t_allOnes();
    int highs;
    writeReg(1'b1, 16'h0001);
    pulse(16'h0100);
    highs = 0;
    for (int i = 0; i < 4; i++) begin cyc(); if (irqReq) highs++; end
    check(highs == 0, "R6 unmasked error no irq", 16'(highs), 16'd0);
    writeReg(1'b1, 16'hFFFF);
    check(irqReq == 1'b0, "R7 edge of mask load", {15'd0, irqReq}, 16'h0000);
    cyc();
    check(irqReq == 1'b1, "R7 all-ones mask passes error", {15'd0, irqReq}, 16'h0001);
  endtask

  initial begin
    rst_n = 1'b0; evtIn = '0; liveIn = '0; wrData = '0;
    errIntEn = 1'b0; regSel = 1'b0; rdEn = 1'b0; wrEn = 1'b0;
    cyc(); cyc(); rst_n = 1'b1; cyc();
    t_reset();
    t_latch();
    t_readClear();
    t_sameCycle();
    t_mask();
    t_irq();
    t_allOnes();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0000, 16'h0001);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule